// File: doc/BRIEF.md
# Structural Multiply-Accumulate Unit

This block multiplies two unsigned operands and adds the product into a wider running sum on every enabled clock edge. It is meant as the arithmetic cell of a matrix engine, where one output element is built from a long run of products and the sum register needs headroom above a single product.

The product is not written as a behavioural multiply. An array of AND gates forms one partial-product bit for every pair of operand bits. A chain of ripple rows built from full adders then folds each shifted partial-product row into the sum. The current sum value enters that same network as its first addend, so the multiply and the add share one reduction. The whole path from the sum register back to its input stays a single combinational stage. A pipeline register inside it would split the running sum into interleaved partial sums.

Each edge runs one of three operations. CLEAR zeroes the sum and takes priority. ACCUM adds the product. HOLD keeps the value. An active-low synchronous reset also zeroes the sum.

Top module: `mac_pp_accum`

## Requirements
- R1: With `en` high and `clr` low, the edge writes `acc + a*b` into `acc`. Operands are unsigned and 4 bits by default; `acc` is 8 bits by default.
- R2: With `clr` high, the edge writes zero into `acc`, whatever the value of `en`.
- R3: With `en` and `clr` both low, `acc` keeps its value and the operand values have no effect on it.
- R4: While `rst_n` is low at an edge, `acc` becomes zero on that edge.
- R5: A sum that passes 2^8-1 wraps modulo 2^8, with no saturation and no flag.
- R6: Every one of the 256 operand pairs, accumulated once from zero, yields exactly their product.
- R7: Accumulations on consecutive edges each build on the previous edge's result, so N back-to-back products form one running sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Accumulate enable |
| clr | input | 1 | Synchronous clear, overrides `en` |
| a | input | A_W (4) | Unsigned multiplicand |
| b | input | B_W (4) | Unsigned multiplier |
| acc | output | ACC_W (8) | Running sum |

## Verification
The properties assume that `en`, `clr`, `a` and `b` hold known values, with no X or Z, at every rising edge after reset is released. They also assume that the reference sum can be formed from the sampled values of the previous cycle. The bench drives every input on the falling edge from tasks that always assign all four of them. As a result, no edge ever samples a changing or undriven input.

// File: rtl/mac_pp_pkg.sv
package mac_pp_pkg;
    localparam int DEF_A_W   = 4;
    localparam int DEF_B_W   = 4;
    localparam int DEF_ACC_W = 8;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_ACCUM = 2'd1,
        OP_CLEAR = 2'd2
    } mac_op_e;
endpackage

// File: rtl/mac_fa.sv
module mac_fa (
    input  logic x,
    input  logic y,
    input  logic z,
    output logic s,
    output logic co
);
    assign s  = x ^ y ^ z;
    assign co = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/mac_pp_gen.sv
module mac_pp_gen #(
    parameter int A_W = 4,
    parameter int B_W = 4
) (
    input  logic [A_W-1:0]            a,
    input  logic [B_W-1:0]            b,
    output logic [B_W-1:0][A_W-1:0]   pp
);
    for (genvar j = 0; j < B_W; j++) begin : g_row
        for (genvar i = 0; i < A_W; i++) begin : g_bit
            assign pp[j][i] = a[i] & b[j];
        end
    end
endmodule

// File: rtl/mac_row_fold.sv
module mac_row_fold #(
    parameter int W   = 8,
    parameter int P   = 4,
    parameter int SH  = 0
) (
    input  logic [W-1:0] sum_in,
    input  logic [P-1:0] row,
    output logic [W-1:0] sum_out
);
    localparam int NC = W - SH;
    logic [NC-1:0] cy;
    assign cy[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_col
        if (i < SH) begin : g_pass
            assign sum_out[i] = sum_in[i];
        end else begin : g_add
            logic rb;
            if (i - SH < P) begin : g_rb
                assign rb = row[i-SH];
            end else begin : g_rz
                assign rb = 1'b0;
            end
            if (i == W - 1) begin : g_top
                assign sum_out[i] = sum_in[i] ^ rb ^ cy[i-SH];
            end else begin : g_fa
                mac_fa u_fa (
                    .x  (sum_in[i]),
                    .y  (rb),
                    .z  (cy[i-SH]),
                    .s  (sum_out[i]),
                    .co (cy[i-SH+1])
                );
            end
        end
    end
endmodule

// File: rtl/mac_reduce.sv
module mac_reduce #(
    parameter int A_W   = 4,
    parameter int B_W   = 4,
    parameter int ACC_W = 8
) (
    input  logic [ACC_W-1:0]          addend,
    input  logic [B_W-1:0][A_W-1:0]   pp,
    output logic [ACC_W-1:0]          total
);
    logic [ACC_W-1:0] stage [0:B_W];
    assign stage[0] = addend;

    for (genvar j = 0; j < B_W; j++) begin : g_fold
        mac_row_fold #(
            .W  (ACC_W),
            .P  (A_W),
            .SH (j)
        ) u_row (
            .sum_in  (stage[j]),
            .row     (pp[j]),
            .sum_out (stage[j+1])
        );
    end

    assign total = stage[B_W];
endmodule

// File: rtl/mac_pp_accum.sv
module mac_pp_accum
    import mac_pp_pkg::*;
#(
    parameter int A_W   = DEF_A_W,
    parameter int B_W   = DEF_B_W,
    parameter int ACC_W = DEF_ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [A_W-1:0]   a,
    input  logic [B_W-1:0]   b,
    output logic [ACC_W-1:0] acc
);
    logic [B_W-1:0][A_W-1:0] pp;
    logic [ACC_W-1:0]        folded;
    logic [ACC_W-1:0]        acc_next;
    mac_op_e                 op;

    mac_pp_gen #(.A_W(A_W), .B_W(B_W)) u_pp (
        .a  (a),
        .b  (b),
        .pp (pp)
    );

    mac_reduce #(.A_W(A_W), .B_W(B_W), .ACC_W(ACC_W)) u_red (
        .addend (acc),
        .pp     (pp),
        .total  (folded)
    );

    always_comb begin
        if (clr)      op = OP_CLEAR;
        else if (en)  op = OP_ACCUM;
        else          op = OP_HOLD;
    end

    always_comb begin
        unique case (op)
            OP_CLEAR: acc_next = '0;
            OP_ACCUM: acc_next = folded;
            OP_HOLD:  acc_next = acc;
            default:  acc_next = acc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc <= '0;
        else        acc <= acc_next;
    end
endmodule

// File: rtl/mac_pp_accum_chk.sv
module mac_pp_accum_chk #(
    parameter int A_W   = 4,
    parameter int B_W   = 4,
    parameter int ACC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             clr,
    input logic [A_W-1:0]   a,
    input logic [B_W-1:0]   b,
    input logic [ACC_W-1:0] acc
);
    // R1 R5 R7
    accum_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> acc == ACC_W'($past(acc) + ACC_W'($past(a)) * ACC_W'($past(b))));

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> acc == '0);

    // R3
    hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(acc));

    // R4
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> acc == '0);
endmodule

bind mac_pp_accum mac_pp_accum_chk #(
    .A_W   (A_W),
    .B_W   (B_W),
    .ACC_W (ACC_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .clr   (clr),
    .a     (a),
    .b     (b),
    .acc   (acc)
);

// File: tb/mac_pp_accum_test.sv
module mac_pp_accum_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       clr = 1'b0;
    logic [3:0] a = '0;
    logic [3:0] b = '0;
    logic [7:0] acc;
    logic [7:0] mdl = '0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mac_pp_accum uut (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .clr   (clr),
        .a     (a),
        .b     (b),
        .acc   (acc)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: acc=%0d expected=%0d", req, got, exp);
        end
    endtask

    // drive at a falling edge, let one rising edge pass, return at the next falling edge
    task automatic cyc(input logic e, input logic c, input logic [3:0] x, input logic [3:0] y);
        en = e; clr = c; a = x; b = y;
        if (!rst_n) mdl = '0;
        else if (c) mdl = '0;
        else if (e) mdl = 8'(mdl + 8'(x) * 8'(y));
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cyc(1'b1, 1'b0, 4'hF, 4'hF);
        check("R4 reset", acc, 8'd0);
        rst_n = 1'b1;
        mdl = '0;
    endtask

    task automatic t_all_pairs();
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                cyc(1'b0, 1'b1, 4'h0, 4'h0);
                cyc(1'b1, 1'b0, 4'(x), 4'(y));
                check("R6 pair", acc, 8'(x * y));
            end
        end
    endtask

    task automatic t_hold();
        cyc(1'b0, 1'b1, 4'h0, 4'h0);
        cyc(1'b1, 1'b0, 4'd5, 4'd7);
        check("R1 accum", acc, 8'd35);
        cyc(1'b0, 1'b0, 4'hF, 4'hF);
        check("R3 hold", acc, 8'd35);
        cyc(1'b0, 1'b0, 4'h9, 4'h3);
        check("R3 hold operands", acc, 8'd35);
    endtask

    task automatic t_clear_priority();
        cyc(1'b1, 1'b0, 4'd6, 4'd6);
        check("R1 accum", acc, mdl);
        cyc(1'b1, 1'b1, 4'hF, 4'hF);
        check("R2 clear over enable", acc, 8'd0);
        cyc(1'b0, 1'b1, 4'd3, 4'd3);
        check("R2 clear alone", acc, 8'd0);
    endtask

    task automatic t_wrap();
        cyc(1'b0, 1'b1, 4'h0, 4'h0);
        cyc(1'b1, 1'b0, 4'hF, 4'hF);
        check("R5 first", acc, 8'd225);
        cyc(1'b1, 1'b0, 4'hF, 4'hF);
        check("R5 wrap", acc, 8'd194);
        cyc(1'b1, 1'b0, 4'd2, 4'd7);
        check("R5 wrap more", acc, 8'd208);
    endtask

    task automatic t_back_to_back();
        cyc(1'b0, 1'b1, 4'h0, 4'h0);
        for (int k = 1; k <= 6; k++) begin
            cyc(1'b1, 1'b0, 4'(k), 4'(k + 1));
        end
        // 2+6+12+20+30+42 = 112
        check("R7 back to back", acc, 8'd112);
        for (int n = 0; n < 400; n++) begin
            cyc(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 19) == 0),
                4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)));
            check("R7 random sequence", acc, mdl);
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_all_pairs();
        t_hold();
        t_clear_priority();
        t_wrap();
        t_back_to_back();
        t_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: acc=%0d expected=finish", acc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule